// File: doc/BRIEF.md
# Conversion Result Window Compare Filter

This block sits between a converter's corrected result and the result register that software and DMA read. Each time the converter presents a result, the filter captures the value with the comparison settings and judges it against two programmable thresholds. A passing result is written to the result register, sets the sticky done flag, and raises a DMA request. A failing result is dropped without any trace. The result register keeps its old value, the flag is left alone, and no request is made. When comparison is switched off, every result passes.

Two configuration bits choose the acceptance region, giving mode = {range_en, gt_sel}. Modes 0 and 1 test against threshold 1 alone. Modes 2 and 3 use both thresholds, and the region they form depends on which threshold is larger. The same two thresholds can therefore describe an inside window or an outside window. Every boundary test is inclusive, so a result equal to a threshold counts as satisfying that side of the test. In differential mode, values and thresholds are compared as two's complement. In single-ended mode they are compared as unsigned.

The filter is a small state machine with four states:
- IDLE waits for a result.
- JUDGE holds the captured sample while the region is evaluated.
- TAKE commits a passing result.
- DROP discards a failing one.

The transitions are:
- IDLE→JUDGE when a result is valid.
- JUDGE→TAKE when the verdict is pass.
- JUDGE→DROP when the verdict is fail.
- TAKE→IDLE and DROP→IDLE unconditionally.

In continuous mode the filter asks for another conversion after every verdict. In single mode it asks again only after a drop, so that a later passing result can still be caught.

Top module: `wcf_top`

## Requirements
- R1: After reset the result register reads 0, the done flag is 0, and the store, drop, DMA request and next-conversion outputs are 0.
- R2: With comparison disabled (cmp_en_i=0), every result is stored, whatever the mode and thresholds.
- R3: Mode 0 (range_en_i=0, gt_sel_i=0) accepts a result x exactly when x <= threshold 1.
- R4: Mode 1 (range_en_i=0, gt_sel_i=1) accepts x exactly when x >= threshold 1.
- R5: Mode 2 (range_en_i=1, gt_sel_i=0) behaves as follows:
  - When threshold 1 <= threshold 2, it accepts x when x <= t1 or x >= t2.
  - When t1 > t2, it accepts x when x <= t1 and x >= t2.
- R6: Mode 3 (range_en_i=1, gt_sel_i=1) behaves as follows:
  - When t1 <= t2, it accepts x when x >= t1 and x <= t2.
  - When t1 > t2, it accepts x when x >= t1 or x <= t2.
- R7: The signedness of all comparisons, including the ordering of the two thresholds, depends on diff_mode_i:
  - With diff_mode_i=1, they are signed two's complement of width W.
  - With diff_mode_i=0, they are unsigned.
- R8: Results are handled with the following timing:
  - A result sampled in IDLE at clock edge k gives a one-cycle store_o pulse (pass) or drop_o pulse (fail) after edge k+1.
  - On a pass, res_q_o holds the sample after edge k+2.
  - On a drop, res_q_o and done_flag_o are unchanged.
- R9: dma_req_o pulses together with store_o when dma_en_i=1 and stays 0 otherwise. irq_o equals done_flag_o AND irq_en_i.
- R10: next_conv_o pulses in the verdict cycle when cont_mode_i was 1 at capture, or when the result was dropped.
- R11: done_flag_o behaves as follows:
  - It is set by a store.
  - It is cleared one edge after flag_clr_i is high.
  - A store in the same cycle as a clear wins, and the flag stays set.
- R12: Comparison settings and thresholds are captured with the result. Changes made while a result is being judged do not alter its verdict.
- R13: res_valid_i is ignored outside IDLE. A second result presented during JUDGE is neither stored nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid_i | input | 1 | Corrected result present this cycle |
| res_data_i | input | W | Corrected conversion result |
| cmp_en_i | input | 1 | Enables window comparison |
| gt_sel_i | input | 1 | Greater-than select (mode bit 0) |
| range_en_i | input | 1 | Two-threshold range enable (mode bit 1) |
| diff_mode_i | input | 1 | 1: signed compare, 0: unsigned |
| cont_mode_i | input | 1 | Continuous conversion mode |
| lim1_i | input | W | Threshold 1 |
| lim2_i | input | W | Threshold 2 |
| irq_en_i | input | 1 | Interrupt enable |
| dma_en_i | input | 1 | DMA request enable |
| flag_clr_i | input | 1 | Clears the done flag |
| res_q_o | output | W | Result register |
| done_flag_o | output | 1 | Sticky conversion-done flag |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | One-cycle DMA request on store |
| store_o | output | 1 | One-cycle pulse: result accepted |
| drop_o | output | 1 | One-cycle pulse: result rejected |
| next_conv_o | output | 1 | Request for another conversion |

## Verification
The bench runs the design at width 4 and sweeps the following:
- every sample value;
- every threshold-1 value;
- eight threshold-2 values, on both sides of threshold 1;
- all four modes, each in both signed and unsigned compare.

This sweep separates inclusive from strict boundaries and ordered from reversed thresholds. It also separates signed from unsigned ordering, since values 8 to 15 flip sides. A sweep with comparison disabled shows that acceptance is unconditional. Directed sequences cover the following:
- settings changed mid-judgement;
- a second result arriving during JUDGE;
- a flag clear colliding with a store;
- the interrupt and DMA gating.

// File: rtl/wcf_pkg.sv
package wcf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_JUDGE = 2'd1,
        ST_TAKE  = 2'd2,
        ST_DROP  = 2'd3
    } wcf_state_e;

    // region select is {range_en, gt_sel}
    typedef enum logic [1:0] {
        RG_BELOW   = 2'd0,
        RG_ABOVE   = 2'd1,
        RG_OUTSIDE = 2'd2,
        RG_INSIDE  = 2'd3
    } wcf_region_e;

    typedef struct packed {
        logic        enable;
        wcf_region_e region;
        logic        signed_cmp;
        logic        cont;
    } wcf_cfg_t;

endpackage

// File: rtl/wcf_region.sv
module wcf_region
    import wcf_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] sample_i,
    input  logic [W-1:0] lim1_i,
    input  logic [W-1:0] lim2_i,
    input  wcf_cfg_t     cfg_i,
    output logic         pass_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] s_b, a_b, b_b;
    logic         le1, ge1, le2, ge2, ordered;

    // flipping the sign bit maps two's complement onto unsigned order
    always_comb begin
        s_b = sample_i;
        a_b = lim1_i;
        b_b = lim2_i;
        if (cfg_i.signed_cmp) begin
            s_b[MSB] = ~sample_i[MSB];
            a_b[MSB] = ~lim1_i[MSB];
            b_b[MSB] = ~lim2_i[MSB];
        end
    end

    assign le1     = (s_b <= a_b);
    assign ge1     = (s_b >= a_b);
    assign le2     = (s_b <= b_b);
    assign ge2     = (s_b >= b_b);
    assign ordered = (a_b <= b_b);

    always_comb begin
        pass_o = 1'b1;
        if (cfg_i.enable) begin
            unique case (cfg_i.region)
                RG_BELOW:   pass_o = le1;
                RG_ABOVE:   pass_o = ge1;
                RG_OUTSIDE: pass_o = ordered ? (le1 | ge2) : (le1 & ge2);
                RG_INSIDE:  pass_o = ordered ? (ge1 & le2) : (ge1 | le2);
                default:    pass_o = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/wcf_fsm.sv
module wcf_fsm
    import wcf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic res_valid_i,
    input  logic verdict_i,
    output logic capture_o,
    output logic take_o,
    output logic drop_o
);
    wcf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (res_valid_i) state_d = ST_JUDGE;
            ST_JUDGE: state_d = verdict_i ? ST_TAKE : ST_DROP;
            ST_TAKE:  state_d = ST_IDLE;
            ST_DROP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture_o = 1'b0;
        take_o    = 1'b0;
        drop_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:  capture_o = res_valid_i;
            ST_JUDGE: ;
            ST_TAKE:  take_o = 1'b1;
            ST_DROP:  drop_o = 1'b1;
            default:  ;
        endcase
    end

    a_r8_judge_resolves: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE) |=> (state_q == ST_TAKE || state_q == ST_DROP));
    a_r8_verdict_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o || drop_o) |=> (state_q == ST_IDLE));
    a_r13_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_JUDGE));

endmodule

// File: rtl/wcf_result.sv
module wcf_result #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         store_i,
    input  logic [W-1:0] data_i,
    input  logic         flag_clr_i,
    output logic [W-1:0] res_q_o,
    output logic         flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q_o <= '0;
            flag_o  <= 1'b0;
        end else begin
            if (store_i) res_q_o <= data_i;
            if (store_i)         flag_o <= 1'b1;
            else if (flag_clr_i) flag_o <= 1'b0;
        end
    end

    a_r8_hold_unless_store: assert property (@(posedge clk) disable iff (!rst_n)
        !store_i |=> $stable(res_q_o));
    a_r11_store_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        store_i |=> flag_o);
    a_r11_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !store_i) |=> !flag_o);

endmodule

// File: rtl/wcf_top.sv
module wcf_top
    import wcf_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         res_valid_i,
    input  logic [W-1:0] res_data_i,
    input  logic         cmp_en_i,
    input  logic         gt_sel_i,
    input  logic         range_en_i,
    input  logic         diff_mode_i,
    input  logic         cont_mode_i,
    input  logic [W-1:0] lim1_i,
    input  logic [W-1:0] lim2_i,
    input  logic         irq_en_i,
    input  logic         dma_en_i,
    input  logic         flag_clr_i,
    output logic [W-1:0] res_q_o,
    output logic         done_flag_o,
    output logic         irq_o,
    output logic         dma_req_o,
    output logic         store_o,
    output logic         drop_o,
    output logic         next_conv_o
);
    logic [W-1:0] hold_data, hold_l1, hold_l2;
    wcf_cfg_t     hold_cfg;
    logic         capture, take, drop, verdict;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_l1   <= '0;
            hold_l2   <= '0;
            hold_cfg  <= '0;
        end else if (capture) begin
            hold_data           <= res_data_i;
            hold_l1             <= lim1_i;
            hold_l2             <= lim2_i;
            hold_cfg.enable     <= cmp_en_i;
            hold_cfg.region     <= wcf_region_e'({range_en_i, gt_sel_i});
            hold_cfg.signed_cmp <= diff_mode_i;
            hold_cfg.cont       <= cont_mode_i;
        end
    end

    wcf_region #(.W(W)) u_region (
        .sample_i(hold_data),
        .lim1_i  (hold_l1),
        .lim2_i  (hold_l2),
        .cfg_i   (hold_cfg),
        .pass_o  (verdict)
    );

    wcf_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_valid_i(res_valid_i),
        .verdict_i  (verdict),
        .capture_o  (capture),
        .take_o     (take),
        .drop_o     (drop)
    );

    wcf_result #(.W(W)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_i   (take),
        .data_i    (hold_data),
        .flag_clr_i(flag_clr_i),
        .res_q_o   (res_q_o),
        .flag_o    (done_flag_o)
    );

    assign store_o     = take;
    assign drop_o      = drop;
    assign dma_req_o   = take & dma_en_i;
    assign irq_o       = done_flag_o & irq_en_i;
    assign next_conv_o = drop | (take & hold_cfg.cont);

    a_r10_drop_requests_more: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> next_conv_o);
    a_r9_dma_only_on_store: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |-> store_o);
    a_r2_disabled_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !cmp_en_i) |=> ##1 !drop_o);

endmodule

// File: tb/sim_wcf_top.sv
module sim_wcf_top;
    localparam int W = 4;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 1 << (W - 1);
    localparam int FULL = 1 << W;
    localparam int T2L [8] = '{0, 2, 5, 7, 8, 9, 13, 15};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic res_valid = 1'b0;
    logic [W-1:0] res_data = '0;
    logic cmp_en = 1'b0, gt_sel = 1'b0, range_en = 1'b0, diff_mode = 1'b0, cont_mode = 1'b0;
    logic [W-1:0] lim1 = '0, lim2 = '0;
    logic irq_en = 1'b0, dma_en = 1'b0, flag_clr = 1'b0;
    logic [W-1:0] res_q;
    logic done_flag, irq, dma_req, store, drop, next_conv;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int prev_q = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wcf_top #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .res_valid_i(res_valid), .res_data_i(res_data),
        .cmp_en_i(cmp_en), .gt_sel_i(gt_sel), .range_en_i(range_en),
        .diff_mode_i(diff_mode), .cont_mode_i(cont_mode),
        .lim1_i(lim1), .lim2_i(lim2), .irq_en_i(irq_en), .dma_en_i(dma_en),
        .flag_clr_i(flag_clr), .res_q_o(res_q), .done_flag_o(done_flag),
        .irq_o(irq), .dma_req_o(dma_req), .store_o(store), .drop_o(drop),
        .next_conv_o(next_conv)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sv(input int v, input bit sg);
        return (sg && v >= HALF) ? v - FULL : v;
    endfunction

    function automatic bit model(input int x0, input int a0, input int b0,
                                 input int md, input bit sg, input bit en);
        int x, a, b;
        x = sv(x0, sg); a = sv(a0, sg); b = sv(b0, sg);
        if (!en) return 1'b1;
        case (md)
            0: return x <= a;
            1: return x >= a;
            2: return (a <= b) ? (x <= a || x >= b) : (x <= a && x >= b);
            default: return (a <= b) ? (x >= a && x <= b) : (x >= a || x <= b);
        endcase
    endfunction

    // one result through the filter; flag cleared afterwards
    task automatic run_one(input int x, input bit exp_pass, input string req);
        @(negedge clk); res_valid = 1'b1; res_data = W'(x);
        @(negedge clk); res_valid = 1'b0;
        @(negedge clk);
        chk(store == exp_pass, {req, "/R8 store"}, store, exp_pass);
        chk(drop == !exp_pass, {req, "/R8 drop"}, drop, !exp_pass);
        chk(next_conv == (cont_mode | !exp_pass), {req, "/R10 next"}, next_conv, cont_mode | !exp_pass);
        chk(dma_req == (exp_pass & dma_en), {req, "/R9 dma"}, dma_req, exp_pass & dma_en);
        @(negedge clk);
        if (exp_pass) prev_q = x;
        chk(res_q == W'(prev_q), {req, "/R8 result"}, res_q, prev_q);
        chk(done_flag == exp_pass, {req, "/R8 flag"}, done_flag, exp_pass);
        flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk(done_flag == 1'b0, "R11 clear", done_flag, 0);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected<=190000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : main
        string tag;
        repeat (3) @(negedge clk);
        chk(res_q == 0, "R1 result", res_q, 0);
        chk(done_flag == 0, "R1 flag", done_flag, 0);
        chk({store, drop, dma_req, next_conv} == 4'b0, "R1 pulses", {store, drop, dma_req, next_conv}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({store, drop, dma_req, next_conv, done_flag} == 5'b0, "R1 after release",
            {store, drop, dma_req, next_conv, done_flag}, 0);

        // R2: comparison disabled
        cmp_en = 1'b0;
        for (int md = 0; md < 4; md++) begin
            {range_en, gt_sel} = 2'(md);
            lim1 = 4'd6; lim2 = 4'd9;
            for (int x = 0; x < FULL; x += 5) run_one(x, 1'b1, "R2");
        end

        // R3..R7 sweep
        cmp_en = 1'b1;
        dma_en = 1'b1;
        for (int sg = 0; sg < 2; sg++) begin
            diff_mode = sg[0];
            for (int md = 0; md < 4; md++) begin
                {range_en, gt_sel} = 2'(md);
                cont_mode = md[0];
                tag = (md == 0) ? "R3" : (md == 1) ? "R4" : (md == 2) ? "R5" : "R6";
                if (sg == 1) tag = {tag, "/R7"};
                for (int a = 0; a < FULL; a++) begin
                    for (int bi = 0; bi < 8; bi++) begin
                        lim1 = W'(a); lim2 = W'(T2L[bi]);
                        for (int x = 0; x < FULL; x++)
                            run_one(x, model(x, a, T2L[bi], md, sg[0], 1'b1), tag);
                    end
                end
            end
        end
        diff_mode = 1'b0; cont_mode = 1'b0; dma_en = 1'b0;

        // R12: settings changed while judging
        {range_en, gt_sel} = 2'd0; lim1 = 4'd2;
        @(negedge clk); res_valid = 1'b1; res_data = 4'd1;
        @(negedge clk); res_valid = 1'b0; lim1 = 4'd0; gt_sel = 1'b1; cmp_en = 1'b1;
        @(negedge clk);
        chk(store == 1'b1, "R12 verdict uses captured settings", store, 1);
        @(negedge clk);
        chk(res_q == 4'd1, "R12 result", res_q, 1);
        prev_q = 1;
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;

        // R13: second result during JUDGE ignored
        cmp_en = 1'b0;
        @(negedge clk); res_valid = 1'b1; res_data = 4'd3;
        @(negedge clk); res_data = 4'd9;
        @(negedge clk); res_valid = 1'b0;
        chk(store == 1'b1, "R13 first stored", store, 1);
        @(negedge clk);
        chk(res_q == 4'd3, "R13 result", res_q, 3);
        @(negedge clk);
        chk(store == 1'b0 && drop == 1'b0, "R13 no second verdict", {store, drop}, 0);
        @(negedge clk);
        chk(res_q == 4'd3, "R13 result kept", res_q, 3);

        // R11: store wins over simultaneous clear; R9 irq gating
        @(negedge clk); res_valid = 1'b1; res_data = 4'd7;
        @(negedge clk); res_valid = 1'b0;
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk(done_flag == 1'b1, "R11 set wins", done_flag, 1);
        irq_en = 1'b0; #1;
        chk(irq == 1'b0, "R9 irq masked", irq, 0);
        irq_en = 1'b1; #1;
        chk(irq == 1'b1, "R9 irq raised", irq, 1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk(irq == 1'b0, "R9 irq follows flag", irq, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule